// File: doc/BRIEF.md
# Word RAM Ownership Handshake Register

This block holds the 8-bit memory-mode register through which a main CPU and a sub CPU pass ownership of a shared word RAM. Each CPU has its own byte-wide write port. Each side may change only the fields it owns, and bits it does not own are kept from the current value. The register is read back on one shared output. Two layouts are supported. In the whole-RAM layout (2M) one CPU owns the entire RAM at a time. In the split layout (1M) each CPU owns one half, and the halves are swapped on request.

Two flags carry the handshake: REQ (bit 1), the main CPU's request, and RETURN (bit 0), the sub CPU's hand-back. A hidden two-bit whole-RAM handshake state is updated in both layouts. In the whole-RAM layout the visible flags always mirror that hidden state. In the split layout the main CPU's REQ write has inverted meaning, and a sub CPU write that changes its fields ends a swap.

The block raises single-cycle pulses for three events: a word RAM remap, a layout conversion into the split layout, and a layout conversion back to the whole-RAM layout. The RAM data path and the conversion logic itself lie outside the block.

The layout bit is the state of the block. Its two states are `WM_2M` (whole RAM) and `WM_1M` (split). There are four transitions:
- `WM_2M -> WM_2M`: a sub write with bit 2 = 0.
- `WM_2M -> WM_1M`: a sub write with bit 2 = 1.
- `WM_1M -> WM_1M`: a sub write with bit 2 = 1.
- `WM_1M -> WM_2M`: a sub write with bit 2 = 0.

Main CPU writes never change the state.

Top module: `wram_handshake`

## Requirements
- R1: After reset the register reads 0x01 (RETURN = 1, REQ = 0, layout bit 2 = 0 meaning whole-RAM, bank 0). The hidden state is RETURN = 1, REQ = 0, so the sub CPU owns the RAM (`wram_main` = 0). All pulses are low.
- R2: A main write affects only bits 7:6 and bit 1. A sub write affects only bits 0, 2, 3 and 4. Bit 5 always reads 0.
- R3: A main write with bit 1 = 1 sets hidden REQ and clears hidden RETURN. A sub write with bit 0 = 1 sets hidden RETURN and clears hidden REQ. Writing 0 to either bit leaves the hidden state unchanged. This happens in both layouts. While bit 2 = 0, visible bits 1:0 equal the hidden state on the cycle after each write.
- R4: In the split layout, a main write with bit 1 = 0 sets visible REQ. A main write with bit 1 = 1 leaves visible REQ unchanged.
- R5: In the split layout, a sub write that changes bit 0 or bit 2 clears visible REQ (swap done).
- R6: A sub write that leaves bit 2 = 1 and changes any of bits 0, 2, 3 or 4 gives one `remap_pulse` on the cycle after the write. A cycle without a sub write gives no pulse the next cycle.
- R7: A sub write that moves bit 2 from 0 to 1 gives `to1m_pulse` and `remap_pulse` together, on the cycle after the write.
- R8: A sub write that moves bit 2 from 1 to 0 gives `to2m_pulse` and `remap_pulse`, on the cycle after the write. Bits 1:0 then take the hidden state.
- R9: When both CPUs write in the same cycle, the main write is applied first. The sub write is then applied to the result, and this order also holds for the hidden state.
- R10: `prg_bank` equals bits 7:6 and `mode_1m` equals bit 2. `wram_main` is 1 exactly when bit 2 = 0 and bit 1 = 1. `half_sel` is 1 exactly when bit 2 = 1 and bit 0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_we | input | 1 | Main CPU write strobe |
| m_wdata | input | 8 | Main CPU write byte |
| s_we | input | 1 | Sub CPU write strobe |
| s_wdata | input | 8 | Sub CPU write byte |
| rd_data | output | 8 | Current register value |
| mode_1m | output | 1 | 1 = split layout |
| prg_bank | output | 2 | Program RAM bank field |
| wram_main | output | 1 | Whole-RAM layout and main CPU owns the RAM |
| half_sel | output | 1 | Split layout half assignment (RETURN bit) |
| remap_pulse | output | 1 | Word RAM remap request |
| to1m_pulse | output | 1 | Conversion to split layout |
| to2m_pulse | output | 1 | Conversion to whole-RAM layout |

## Verification
The assertions assume that both write strobes and their data are known, non-X values at every sampled edge after reset. They also assume that a strobe held high counts as one fresh write on each edge. The bench drives every input with a defined value on the falling edge, including during idle cycles, so no X ever reaches a sampled edge. It freely mixes same-cycle writes from both CPUs with single-port writes, because the checks compare against the stated main-then-sub order instead of avoiding it.

// File: rtl/wram_hs_pkg.sv
package wram_hs_pkg;
    localparam int REG_W     = 8;
    localparam int BANK_W    = 2;
    localparam int BIT_RET   = 0;
    localparam int BIT_REQ   = 1;
    localparam int BIT_MODE  = 2;
    localparam int BANK_LSB  = REG_W - BANK_W;
    localparam logic [REG_W-1:0] MAIN_MASK  = 8'hC2;
    localparam logic [REG_W-1:0] SUB_MASK   = 8'h1D;
    localparam logic [REG_W-1:0] REMAP_MASK = 8'h1D;
    localparam logic [REG_W-1:0] SWAP_MASK  = 8'h05;
    localparam logic [REG_W-1:0] RESET_VAL  = 8'h01;
    localparam logic [REG_W-1:0] FLAG_MASK  = 8'h03;

    typedef enum logic {
        WM_2M = 1'b0,
        WM_1M = 1'b1
    } wmode_e;
endpackage

// File: rtl/wram_hs_shadow.sv
module wram_hs_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic main_set,
    input  logic sub_set,
    output logic mid_ret,
    output logic mid_req,
    output logic nxt_ret,
    output logic nxt_req,
    output logic q_ret,
    output logic q_req
);
    // main first, then sub on top of the result
    always_comb begin
        mid_ret = main_set ? 1'b0 : q_ret;
        mid_req = main_set ? 1'b1 : q_req;
        nxt_ret = sub_set  ? 1'b1 : mid_ret;
        nxt_req = sub_set  ? 1'b0 : mid_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ret <= 1'b1;
            q_req <= 1'b0;
        end else begin
            q_ret <= nxt_ret;
            q_req <= nxt_req;
        end
    end

    p_hidden_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_ret && q_req));
endmodule

// File: rtl/wram_hs_main_stage.sv
module wram_hs_main_stage
    import wram_hs_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             sh_ret,
    input  logic             sh_req,
    output logic [REG_W-1:0] nxt
);
    logic [REG_W-1:0] flipped;
    logic [REG_W-1:0] hidden;

    always_comb begin
        flipped = wdata ^ (REG_W'(1) << BIT_REQ);
        hidden  = '0;
        hidden[BIT_RET] = sh_ret;
        hidden[BIT_REQ] = sh_req;
        nxt = cur;
        if (we) begin
            unique case (wmode_e'(cur[BIT_MODE]))
                WM_1M: nxt = (flipped & MAIN_MASK) | (cur & (SUB_MASK | FLAG_MASK));
                WM_2M: nxt = (wdata & MAIN_MASK & ~FLAG_MASK)
                           | (cur & SUB_MASK & ~FLAG_MASK) | hidden;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/wram_hs_sub_stage.sv
module wram_hs_sub_stage
    import wram_hs_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             sh_ret,
    input  logic             sh_req,
    output logic [REG_W-1:0] nxt,
    output logic             remap,
    output logic             to1m,
    output logic             to2m
);
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] hidden;
    logic [REG_W-1:0] diff;

    always_comb begin
        merged = (wdata & SUB_MASK) | (cur & MAIN_MASK);
        diff   = merged ^ cur;
        hidden = '0;
        hidden[BIT_RET] = sh_ret;
        hidden[BIT_REQ] = sh_req;
        nxt   = cur;
        remap = 1'b0;
        to1m  = 1'b0;
        to2m  = 1'b0;
        if (we) begin
            unique case (wmode_e'(merged[BIT_MODE]))
                WM_1M: begin
                    to1m  = (wmode_e'(cur[BIT_MODE]) == WM_2M);
                    remap = |(diff & REMAP_MASK);
                    nxt   = merged;
                    if (|(diff & SWAP_MASK))
                        nxt[BIT_REQ] = 1'b0;
                end
                WM_2M: begin
                    to2m  = (wmode_e'(cur[BIT_MODE]) == WM_1M);
                    remap = to2m;
                    nxt   = (merged & ~FLAG_MASK) | hidden;
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/wram_handshake.sv
module wram_handshake
    import wram_hs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    m_we,
    input  logic [REG_W-1:0]        m_wdata,
    input  logic                    s_we,
    input  logic [REG_W-1:0]        s_wdata,
    output logic [REG_W-1:0]        rd_data,
    output logic                    mode_1m,
    output logic [BANK_W-1:0]       prg_bank,
    output logic                    wram_main,
    output logic                    half_sel,
    output logic                    remap_pulse,
    output logic                    to1m_pulse,
    output logic                    to2m_pulse
);
    logic [REG_W-1:0] reg_q, after_main, after_sub;
    logic mid_ret, mid_req, fin_ret, fin_req, sh_ret, sh_req;
    logic remap_c, to1m_c, to2m_c;
    wmode_e state;

    wram_hs_shadow u_shadow (
        .clk(clk), .rst_n(rst_n),
        .main_set(m_we && m_wdata[BIT_REQ]),
        .sub_set(s_we && s_wdata[BIT_RET]),
        .mid_ret(mid_ret), .mid_req(mid_req),
        .nxt_ret(fin_ret), .nxt_req(fin_req),
        .q_ret(sh_ret), .q_req(sh_req)
    );

    wram_hs_main_stage u_main (
        .cur(reg_q), .we(m_we), .wdata(m_wdata),
        .sh_ret(mid_ret), .sh_req(mid_req), .nxt(after_main)
    );

    wram_hs_sub_stage u_sub (
        .cur(after_main), .we(s_we), .wdata(s_wdata),
        .sh_ret(fin_ret), .sh_req(fin_req), .nxt(after_sub),
        .remap(remap_c), .to1m(to1m_c), .to2m(to2m_c)
    );

    // state register (layout bit lives inside it)
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= RESET_VAL;
        else        reg_q <= after_sub;
    end

    // event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_pulse <= 1'b0;
            to1m_pulse  <= 1'b0;
            to2m_pulse  <= 1'b0;
        end else begin
            remap_pulse <= remap_c;
            to1m_pulse  <= to1m_c;
            to2m_pulse  <= to2m_c;
        end
    end

    always_comb begin
        state     = wmode_e'(reg_q[BIT_MODE]);
        rd_data   = reg_q;
        mode_1m   = (state == WM_1M);
        prg_bank  = reg_q[REG_W-1:BANK_LSB];
        wram_main = (state == WM_2M) && reg_q[BIT_REQ];
        half_sel  = (state == WM_1M) && reg_q[BIT_RET];
    end

    p_hidden_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WM_2M) |-> (reg_q[BIT_REQ] == sh_req && reg_q[BIT_RET] == sh_ret));
    p_main_keeps_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && !s_we) |=> (reg_q[4:2] == $past(reg_q[4:2])));
    p_sub_keeps_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && !m_we) |=> (reg_q[7:6] == $past(reg_q[7:6])));
    p_bit5_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_q[5]);
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_we |=> !(remap_pulse || to1m_pulse || to2m_pulse));
    p_back_remap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        to2m_pulse |-> (remap_pulse && !mode_1m));
    p_into_remap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        to1m_pulse |-> (remap_pulse && mode_1m));
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_1m && m_we && !s_we && m_wdata[BIT_REQ]) |=> $stable(reg_q[BIT_REQ]));
endmodule

// File: tb/test_wram_handshake.sv
module test_wram_handshake;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_we = 1'b0, s_we = 1'b0;
    logic [7:0] m_wdata = '0, s_wdata = '0;
    logic [7:0] rd_data;
    logic mode_1m, wram_main, half_sel, remap_pulse, to1m_pulse, to2m_pulse;
    logic [1:0] prg_bank;

    int n_chk = 0, n_bad = 0;
    int r, h_ret, h_req, e_remap, e_to1m, e_to2m;

    always #4 clk = ~clk;

    wram_handshake i_wram_handshake (
        .clk(clk), .rst_n(rst_n), .m_we(m_we), .m_wdata(m_wdata),
        .s_we(s_we), .s_wdata(s_wdata), .rd_data(rd_data), .mode_1m(mode_1m),
        .prg_bank(prg_bank), .wram_main(wram_main), .half_sel(half_sel),
        .remap_pulse(remap_pulse), .to1m_pulse(to1m_pulse), .to2m_pulse(to2m_pulse)
    );

    task automatic model(input bit mw, input int md, input bit sw, input int sd);
        int d;
        e_remap = 0; e_to1m = 0; e_to2m = 0;
        if (mw) begin
            if (md & 2) begin h_req = 1; h_ret = 0; end
            if (r & 4) r = ((md ^ 2) & 'hC2) | (r & 'h1F);
            else       r = (md & 'hC0) | (r & 'h1C) | (h_req << 1) | h_ret;
        end
        if (sw) begin
            d = (sd & 'h1D) | (r & 'hC2);
            if (d & 1) begin h_ret = 1; h_req = 0; end
            if (d & 4) begin
                if (!(r & 4)) e_to1m = 1;
                if ((d ^ r) & 'h1D) e_remap = 1;
                if ((d ^ r) & 'h05) d = d & ~2;
            end else begin
                if (r & 4) begin e_to2m = 1; e_remap = 1; end
                d = (d & ~3) | (h_req << 1) | h_ret;
            end
            r = d;
        end
    endtask

    task automatic compare(input string tag);
        logic [14:0] got, exp;
        got = {rd_data, mode_1m, prg_bank, wram_main, half_sel, remap_pulse, to1m_pulse, to2m_pulse};
        exp = {r[7:0], 1'(r >> 2), 2'(r >> 6), 1'(!(r & 4) && (r & 2)),
               1'((r & 4) && (r & 1)), 1'(e_remap), 1'(e_to1m), 1'(e_to2m)};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input bit mw, input int md, input bit sw, input int sd, input string tag);
        @(negedge clk);
        m_we = mw; m_wdata = 8'(md); s_we = sw; s_wdata = 8'(sd);
        @(posedge clk);
        model(mw, md, sw, sd);
        @(negedge clk);
        m_we = 1'b0; s_we = 1'b0;
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        r = 'h01; h_ret = 1; h_req = 0; e_remap = 0; e_to1m = 0; e_to2m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");
        step(1, 'hFF, 0, 0,    "R2 R3 R10 main write 2M");
        step(0, 0,    1, 'h01, "R3 sub return 2M");
        step(0, 0,    1, 'h00, "R3 sub zero no effect");
        step(1, 'h00, 0, 0,    "R3 main zero no effect");
        step(0, 0,    1, 'h04, "R7 enter split layout");
        step(1, 'h02, 0, 0,    "R4 one leaves REQ");
        step(1, 'h00, 0, 0,    "R4 zero sets REQ");
        step(0, 0,    1, 'h0C, "R6 field change remap");
        step(0, 0,    0, 0,    "R6 idle no pulse");
        step(0, 0,    1, 'h0D, "R5 swap clears REQ");
        step(0, 0,    1, 'h0D, "R6 unchanged no remap");
        step(1, 'h00, 0, 0,    "R4 REQ again");
        step(0, 0,    1, 'h08, "R8 back to whole layout");
        step(1, 'h02, 1, 'h01, "R9 both write same cycle");
        step(1, 'h42, 1, 'h14, "R9 R7 both write into split");
        step(1, 'h80, 1, 'h10, "R9 R8 both write back");
        for (int i = 0; i < 2000; i++) begin
            int pick;
            pick = $urandom_range(0, 3);
            step(pick[0], $urandom_range(0, 255), pick[1], $urandom_range(0, 255),
                 "R2 R9 mixed traffic");
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        r = 'h01; h_ret = 1; h_req = 0; e_remap = 0; e_to1m = 0; e_to2m = 0;
        compare("R1 second reset");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule